// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block works out where a 16-bit-instruction processor fetches next when the current instruction is a conditional branch on a status flag, a relative jump or call, or a conditional skip. For each request it takes the current program counter, the current instruction word, the word stored after it, the status register and three condition inputs: a tested register bit, a register-equality result and a tested I/O bit. It returns the next program counter, a flag saying whether control flow left the straight line, and how many cycles the instruction takes (1, 2 or 3).

A skip has to step over whole instructions. The unit therefore inspects the following word to see whether it starts a two-word instruction. A skip over a one-word instruction moves the PC by 2 and takes 2 cycles. A skip over a two-word instruction moves it by 3 and takes 3 cycles. Any word the unit does not recognise advances the PC by one. The result is registered and appears one cycle after the request. Pushing return addresses and the fetch memory belong to neighbouring blocks.

Top module: `branch_skip_npc`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `out_valid`, `next_pc`, `taken` and `cycles` are all zero.
- R2: A request made with `in_valid` high at a rising edge yields `out_valid` high after that edge. A cycle with `in_valid` low yields `out_valid` low after the next edge, and `next_pc`, `taken` and `cycles` keep their values.
- R3: A flag branch is `1111 0Ckk kkkk ksss`. The condition C=0 branches when status bit `sreg_i[s]` is 1, and C=1 branches when that bit is 0. A taken branch gives PC + k + 1, `taken`=1 and 2 cycles. A branch that is not taken gives PC + 1, `taken`=0 and 1 cycle.
- R4: The branch offset k is the 7-bit two's-complement field in bits 9:3. All PC sums wrap modulo 2^PC_W.
- R5: A relative jump `1100 kkkk kkkk kkkk` and a relative call `1101 kkkk kkkk kkkk` both give PC + k + 1, where k is 12-bit two's complement, and set `taken`=1. The jump takes 2 cycles and the call takes 3.
- R6: The equality skip `0001 00xx xxxx xxxx` skips when `equal_i` is 1.
- R7: The register-bit skips `1111 110x xxxx 0xxx` (skip when `reg_bit_i` is 0) and `1111 111x xxxx 0xxx` (skip when `reg_bit_i` is 1) need bit 3 to be 0. With bit 3 set, the word is treated as an unrecognised word.
- R8: The I/O-bit skips `1001 1001 xxxx xxxx` (skip when `io_bit_i` is 0) and `1001 1011 xxxx xxxx` (skip when `io_bit_i` is 1) are handled as skips.
- R9: A taken skip whose following word is two words long gives PC + 3 and 3 cycles. Two-word means `1001 010x xxxx 11xx` (absolute jump or call) or `1001 00xx xxxx 0000` (direct load or store). Any other following word gives PC + 2 and 2 cycles. A skip that is not taken gives PC + 1 and 1 cycle. A taken skip sets `taken`=1.
- R10: Any other instruction word gives PC + 1, `taken`=0 and 1 cycle.
- R11: `cycles` is 1 exactly when `taken` is 0, and it never leaves the range 1 to 3 while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| pc_i | input | PC_W | Address of the current instruction |
| instr_i | input | 16 | Current instruction word |
| follow_i | input | 16 | Word stored after the current instruction |
| sreg_i | input | 8 | Status register |
| reg_bit_i | input | 1 | Value of the register bit being tested |
| equal_i | input | 1 | The two compared registers are equal |
| io_bit_i | input | 1 | Value of the I/O bit being tested |
| out_valid | output | 1 | Result registers hold a fresh result |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Branch, jump, call or skip was taken |
| cycles | output | 2 | Cycle count of the instruction, 1 to 3 |

## Verification
Every result (`next_pc`, `taken`, `cycles`) and `out_valid` is due exactly one rising edge after the request that caused it. The bench drives each request on a falling edge, lets one rising edge pass, and compares all outputs on the following falling edge, before the next request can affect them. For idle cycles it checks, at that same point, that `out_valid` has dropped and that the other outputs are unchanged. Directed cases cover PC wrap-around at both ends of the address space, the largest negative jump, a skip over a two-word instruction near the top of memory, and a register-bit skip word with bit 3 set. Seeded random words from every instruction class make up the rest.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int INSTR_W   = 16;
    localparam int BR_OFF_W  = 7;
    localparam int JMP_OFF_W = 12;
    localparam int FLAG_W    = 3;
    localparam int CYC_W     = 2;

    typedef enum logic [3:0] {
        OP_SEQ,
        OP_BR_ON_SET,
        OP_BR_ON_CLR,
        OP_REL_JUMP,
        OP_REL_CALL,
        OP_SKIP_EQ,
        OP_SKIP_RBIT_CLR,
        OP_SKIP_RBIT_SET,
        OP_SKIP_IO_CLR,
        OP_SKIP_IO_SET
    } op_kind_e;

    // mask / pattern pairs for the current instruction
    localparam logic [INSTR_W-1:0] M_BR    = 16'hFC00;
    localparam logic [INSTR_W-1:0] P_BRSET = 16'hF000;
    localparam logic [INSTR_W-1:0] P_BRCLR = 16'hF400;
    localparam logic [INSTR_W-1:0] M_REL   = 16'hF000;
    localparam logic [INSTR_W-1:0] P_JUMP  = 16'hC000;
    localparam logic [INSTR_W-1:0] P_CALL  = 16'hD000;
    localparam logic [INSTR_W-1:0] M_EQ    = 16'hFC00;
    localparam logic [INSTR_W-1:0] P_EQ    = 16'h1000;
    localparam logic [INSTR_W-1:0] M_RBIT  = 16'hFE08;
    localparam logic [INSTR_W-1:0] P_RCLR  = 16'hFC00;
    localparam logic [INSTR_W-1:0] P_RSET  = 16'hFE00;
    localparam logic [INSTR_W-1:0] M_IO    = 16'hFF00;
    localparam logic [INSTR_W-1:0] P_IOCLR = 16'h9900;
    localparam logic [INSTR_W-1:0] P_IOSET = 16'h9B00;

    // two-word instruction forms (following word)
    localparam int NUM_LONG = 4;
    localparam logic [NUM_LONG-1:0][INSTR_W-1:0] LONG_MASK = {
        16'hFE0F, 16'hFE0F, 16'hFE0E, 16'hFE0E
    };
    localparam logic [NUM_LONG-1:0][INSTR_W-1:0] LONG_PAT = {
        16'h9200, 16'h9000, 16'h940E, 16'h940C
    };

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [INSTR_W-1:0] instr_i,
    output op_kind_e           kind_o,
    output logic [PC_W-1:0]    offset_o,
    output logic [FLAG_W-1:0]  flag_sel_o
);

    localparam int BR_EXT  = PC_W - BR_OFF_W;
    localparam int JMP_EXT = PC_W - JMP_OFF_W;

    function automatic logic hit(input logic [INSTR_W-1:0] w,
                                 input logic [INSTR_W-1:0] m,
                                 input logic [INSTR_W-1:0] p);
        return (w & m) == p;
    endfunction

    logic [PC_W-1:0] br_off, rel_off;

    always_comb begin
        br_off  = {{BR_EXT{instr_i[9]}}, instr_i[9:3]};
        rel_off = {{JMP_EXT{instr_i[11]}}, instr_i[11:0]};
        flag_sel_o = instr_i[FLAG_W-1:0];
        kind_o   = OP_SEQ;
        offset_o = '0;
        if (hit(instr_i, M_BR, P_BRSET)) begin
            kind_o   = OP_BR_ON_SET;
            offset_o = br_off;
        end else if (hit(instr_i, M_BR, P_BRCLR)) begin
            kind_o   = OP_BR_ON_CLR;
            offset_o = br_off;
        end else if (hit(instr_i, M_REL, P_JUMP)) begin
            kind_o   = OP_REL_JUMP;
            offset_o = rel_off;
        end else if (hit(instr_i, M_REL, P_CALL)) begin
            kind_o   = OP_REL_CALL;
            offset_o = rel_off;
        end else if (hit(instr_i, M_EQ, P_EQ)) begin
            kind_o = OP_SKIP_EQ;
        end else if (hit(instr_i, M_RBIT, P_RCLR)) begin
            kind_o = OP_SKIP_RBIT_CLR;
        end else if (hit(instr_i, M_RBIT, P_RSET)) begin
            kind_o = OP_SKIP_RBIT_SET;
        end else if (hit(instr_i, M_IO, P_IOCLR)) begin
            kind_o = OP_SKIP_IO_CLR;
        end else if (hit(instr_i, M_IO, P_IOSET)) begin
            kind_o = OP_SKIP_IO_SET;
        end
    end

endmodule

// File: rtl/npc_len_detect.sv
module npc_len_detect
    import npc_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output logic               two_word_o
);

    logic [NUM_LONG-1:0] match;

    for (genvar g = 0; g < NUM_LONG; g++) begin : g_form
        assign match[g] = (word_i & LONG_MASK[g]) == LONG_PAT[g];
    end

    assign two_word_o = |match;

endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] offset_i,
    input  logic            two_word_i,
    output logic [PC_W-1:0] seq_pc_o,
    output logic [PC_W-1:0] rel_pc_o,
    output logic [PC_W-1:0] skip_pc_o
);

    localparam logic [PC_W-1:0] ONE   = PC_W'(1);
    localparam logic [PC_W-1:0] SKIP1 = PC_W'(2);
    localparam logic [PC_W-1:0] SKIP2 = PC_W'(3);

    always_comb begin
        seq_pc_o  = pc_i + ONE;
        rel_pc_o  = seq_pc_o + offset_i;
        skip_pc_o = pc_i + (two_word_i ? SKIP2 : SKIP1);
    end

endmodule

// File: rtl/branch_skip_npc.sv
module branch_skip_npc
    import npc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [INSTR_W-1:0] follow_i,
    input  logic [7:0]         sreg_i,
    input  logic               reg_bit_i,
    input  logic               equal_i,
    input  logic               io_bit_i,
    output logic               out_valid,
    output logic [PC_W-1:0]    next_pc,
    output logic               taken,
    output logic [CYC_W-1:0]   cycles
);

    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   pc;
        logic              taken;
        logic [CYC_W-1:0]  cycles;
    } npc_state_t;

    op_kind_e          kind;
    logic [PC_W-1:0]   offset;
    logic [FLAG_W-1:0] flag_sel;
    logic              follow_long;
    logic [PC_W-1:0]   seq_pc, rel_pc, skip_pc;
    logic              is_skip, skip_hit, br_hit;

    npc_state_t st_d, st_q;

    npc_decode #(.PC_W(PC_W)) u_dec (
        .instr_i    (instr_i),
        .kind_o     (kind),
        .offset_o   (offset),
        .flag_sel_o (flag_sel)
    );

    npc_len_detect u_len (
        .word_i     (follow_i),
        .two_word_o (follow_long)
    );

    npc_target #(.PC_W(PC_W)) u_tgt (
        .pc_i       (pc_i),
        .offset_i   (offset),
        .two_word_i (follow_long),
        .seq_pc_o   (seq_pc),
        .rel_pc_o   (rel_pc),
        .skip_pc_o  (skip_pc)
    );

    always_comb begin
        br_hit   = 1'b0;
        is_skip  = 1'b0;
        skip_hit = 1'b0;
        unique case (kind)
            OP_BR_ON_SET:     br_hit = sreg_i[flag_sel];
            OP_BR_ON_CLR:     br_hit = !sreg_i[flag_sel];
            OP_SKIP_EQ:       begin is_skip = 1'b1; skip_hit = equal_i;    end
            OP_SKIP_RBIT_CLR: begin is_skip = 1'b1; skip_hit = !reg_bit_i; end
            OP_SKIP_RBIT_SET: begin is_skip = 1'b1; skip_hit = reg_bit_i;  end
            OP_SKIP_IO_CLR:   begin is_skip = 1'b1; skip_hit = !io_bit_i;  end
            OP_SKIP_IO_SET:   begin is_skip = 1'b1; skip_hit = io_bit_i;   end
            default:          ;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.pc     = seq_pc;
            st_d.taken  = 1'b0;
            st_d.cycles = CYC_W'(1);
            if (kind == OP_REL_JUMP) begin
                st_d.pc     = rel_pc;
                st_d.taken  = 1'b1;
                st_d.cycles = CYC_W'(2);
            end else if (kind == OP_REL_CALL) begin
                st_d.pc     = rel_pc;
                st_d.taken  = 1'b1;
                st_d.cycles = CYC_W'(3);
            end else if (br_hit) begin
                st_d.pc     = rel_pc;
                st_d.taken  = 1'b1;
                st_d.cycles = CYC_W'(2);
            end else if (is_skip && skip_hit) begin
                st_d.pc     = skip_pc;
                st_d.taken  = 1'b1;
                st_d.cycles = follow_long ? CYC_W'(3) : CYC_W'(2);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign next_pc   = st_q.pc;
    assign taken     = st_q.taken;
    assign cycles    = st_q.cycles;

endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [PC_W-1:0] pc_i,
    input logic [15:0]     instr_i,
    input logic            out_valid,
    input logic [PC_W-1:0] next_pc,
    input logic            taken,
    input logic [1:0]      cycles
);

    // R2: a request produces a result one edge later
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle cycles drop valid and hold the result
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken) && $stable(cycles)));

    // R11: cycle count stays in 1..3
    p_cycles_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cycles != 2'd0));

    // R11: single cycle exactly when not taken
    p_taken_cycles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (taken == (cycles != 2'd1)));

    // R10: straight-line result steps by one
    p_not_taken_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (next_pc == $past(pc_i) + PC_W'(1)));

    // R9: a three-cycle result that is not a call is a long skip
    p_long_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cycles == 2'd3 && $past(instr_i[15:12]) != 4'hD)
            |-> (next_pc == $past(pc_i) + PC_W'(3)));

endmodule

bind branch_skip_npc npc_checker #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pc_i      (pc_i),
    .instr_i   (instr_i),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .cycles    (cycles)
);

// File: tb/sim_branch_skip_npc.sv
`timescale 1ns/1ps
module sim_branch_skip_npc;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [PW-1:0] pc_i = '0;
    logic [15:0]   instr_i = '0;
    logic [15:0]   follow_i = '0;
    logic [7:0]    sreg_i = '0;
    logic          reg_bit_i = 1'b0;
    logic          equal_i = 1'b0;
    logic          io_bit_i = 1'b0;
    logic          out_valid;
    logic [PW-1:0] next_pc;
    logic          taken;
    logic [1:0]    cycles;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    branch_skip_npc #(.PC_W(PW)) u0 (.*);

    function automatic logic is_long(input logic [15:0] w);
        casez (w)
            16'b1001_010?_????_11??: return 1'b1;
            16'b1001_00??_????_0000: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    task automatic model(input logic [PW-1:0] pc, input logic [15:0] ins,
                         input logic [15:0] nw, input logic [7:0] sr,
                         input logic rb, input logic eq, input logic io,
                         output logic [PW-1:0] e_pc, output logic e_tk,
                         output logic [1:0] e_cy, output string tag);
        int  k;
        logic skip, is_skip;
        is_skip = 1'b0; skip = 1'b0;
        e_pc = pc + 16'd1; e_tk = 1'b0; e_cy = 2'd1; tag = "R10";
        casez (ins)
            16'b1111_00??_????_????, 16'b1111_01??_????_????: begin
                k = int'($signed(ins[9:3]));
                tag = "R3";
                if (sr[ins[2:0]] == !ins[10]) begin
                    e_pc = PW'(int'(pc) + k + 1); e_tk = 1'b1; e_cy = 2'd2;
                end
            end
            16'b1100_????_????_????, 16'b1101_????_????_????: begin
                k = int'($signed(ins[11:0]));
                tag = "R5";
                e_pc = PW'(int'(pc) + k + 1); e_tk = 1'b1;
                e_cy = ins[12] ? 2'd3 : 2'd2;
            end
            16'b0001_00??_????_????: begin is_skip = 1; skip = eq;  tag = "R6"; end
            16'b1111_110?_????_0???: begin is_skip = 1; skip = !rb; tag = "R7"; end
            16'b1111_111?_????_0???: begin is_skip = 1; skip = rb;  tag = "R7"; end
            16'b1001_1001_????_????: begin is_skip = 1; skip = !io; tag = "R8"; end
            16'b1001_1011_????_????: begin is_skip = 1; skip = io;  tag = "R8"; end
            default: ;
        endcase
        if (is_skip && skip) begin
            e_tk = 1'b1;
            if (is_long(nw)) begin
                e_pc = pc + 16'd3; e_cy = 2'd3; tag = "R9";
            end else begin
                e_pc = pc + 16'd2; e_cy = 2'd2;
            end
        end
    endtask

    task automatic apply(input logic [PW-1:0] pc, input logic [15:0] ins,
                         input logic [15:0] nw, input logic [7:0] sr,
                         input logic rb, input logic eq, input logic io,
                         input string extra);
        logic [PW-1:0] e_pc; logic e_tk; logic [1:0] e_cy; string tag;
        model(pc, ins, nw, sr, rb, eq, io, e_pc, e_tk, e_cy, tag);
        in_valid = 1'b1; pc_i = pc; instr_i = ins; follow_i = nw;
        sreg_i = sr; reg_bit_i = rb; equal_i = eq; io_bit_i = io;
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b1 || next_pc !== e_pc || taken !== e_tk || cycles !== e_cy) begin
            n_errors++;
            $display("FAIL %s%s R2 ins=%h pc=%h: got v=%b pc=%h tk=%b cy=%0d exp v=1 pc=%h tk=%b cy=%0d",
                     tag, extra, ins, pc, out_valid, next_pc, taken, cycles, e_pc, e_tk, e_cy);
        end
    endtask

    function automatic logic [15:0] rand_instr();
        logic [15:0] r;
        r = 16'($urandom);
        case ($urandom_range(0, 9))
            0: return (r & ~16'hFC00) | 16'hF000;
            1: return (r & ~16'hFC00) | 16'hF400;
            2: return (r & ~16'hF000) | 16'hC000;
            3: return (r & ~16'hF000) | 16'hD000;
            4: return (r & ~16'hFC00) | 16'h1000;
            5: return (r & ~16'hFE08) | 16'hFC00;
            6: return (r & ~16'hFE08) | 16'hFE00;
            7: return (r & ~16'hFF00) | 16'h9900;
            8: return (r & ~16'hFF00) | 16'h9B00;
            default: return r;
        endcase
    endfunction

    function automatic logic [15:0] rand_follow();
        logic [15:0] r;
        r = 16'($urandom);
        case ($urandom_range(0, 5))
            0: return (r & ~16'hFE0E) | 16'h940C;
            1: return (r & ~16'hFE0E) | 16'h940E;
            2: return (r & ~16'hFE0F) | 16'h9000;
            3: return (r & ~16'hFE0F) | 16'h9200;
            default: return r;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin : stim
        logic [PW-1:0] held;
        process::self().srandom(32'd1357);
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || next_pc !== '0 || taken !== 1'b0 || cycles !== 2'd0) begin
            n_errors++;
            $display("FAIL R1 reset: got v=%b pc=%h tk=%b cy=%0d exp 0 0 0 0",
                     out_valid, next_pc, taken, cycles);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || next_pc !== '0) begin
            n_errors++;
            $display("FAIL R1 after reset idle: got v=%b pc=%h exp v=0 pc=0000", out_valid, next_pc);
        end

        // R3/R4: branch on set flag, offset -1 from 0
        apply(16'h0000, 16'hF3F9, 16'h0000, 8'h02, 0, 0, 0, " R4 back-wrap");
        // R4: forward offset +63 wraps past top
        apply(16'hFFF0, 16'hF1F8, 16'h0000, 8'h01, 0, 0, 0, " R4 fwd-wrap");
        // R3: clear-flag branch not taken
        apply(16'h1234, 16'hF40B, 16'h0000, 8'h08, 0, 0, 0, " not-taken");
        // R5: largest negative jump, then call
        apply(16'h0100, 16'hC800, 16'h0000, 8'h00, 0, 0, 0, " R5 min");
        apply(16'h0100, 16'hD7FF, 16'h0000, 8'h00, 0, 0, 0, " R5 call");
        // R9: skip over a two-word word at top of memory
        apply(16'hFFFE, 16'h1000, 16'h940C, 8'h00, 0, 1, 0, " R9 wrap");
        apply(16'h0010, 16'h9B05, 16'h9200, 8'h00, 0, 0, 1, " R9 io-long");
        apply(16'h0010, 16'h9905, 16'h9201, 8'h00, 0, 0, 0, " R9 short");
        // R7: register-bit form with bit 3 set is not a skip
        apply(16'h0200, 16'hFC08, 16'h0000, 8'h00, 0, 0, 0, " R7 bit3");
        apply(16'h0200, 16'hFE01, 16'h0000, 8'h00, 1, 0, 0, " R7 set");

        // R2: idle cycle
        held = next_pc;
        in_valid = 1'b0;
        pc_i = 16'h5555; instr_i = 16'hC001;
        @(posedge clk); @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || next_pc !== held) begin
            n_errors++;
            $display("FAIL R2 idle: got v=%b pc=%h exp v=0 pc=%h", out_valid, next_pc, held);
        end

        for (int i = 0; i < 3000; i++) begin
            apply(16'($urandom), rand_instr(), rand_follow(), 8'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), " rnd");
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule